// File: doc/BRIEF.md
# Feed-Forward Frequency Compensation Loop

This block sits beside the bang-bang phase loop of a digital phase-interpolator clock and data recovery circuit. It targets a frequency offset that drifts slowly, as with a spread-spectrum transmit clock. The loop filter sends single-cycle step pulses toward the phase control. This block watches those pulses and, over each fixed window of 512 clock cycles, takes the net count: advance steps minus retard steps.

At each window boundary the net count is added to a signed, saturating compensation value. Throughout the next window the block emits exactly as many phase-step pulses as the magnitude of that value. A positive value sends the pulses on the advance output and a negative value sends them on the retard output. The pulses are spaced as evenly as the 512-cycle window allows. The phase control merges them with the phase-loop steps, and each one moves the recovered clock by one interpolator step. The phase loop therefore only has to follow the residual error, not the whole ramp of the frequency sweep.

Top module: `freq_comp_loop`

## Requirements
- R1: While `rst_n` is low and through the first window after it rises, both `step_adv` and `step_ret` stay low, and the compensation value starts at zero.
- R2: A window is 512 cycles long. Cycle 0 is the first cycle after `rst_n` rises, and an input pulse sampled in cycle c belongs to window floor(c/512). The net count of a window is the number of cycles with only `loop_adv` high minus the number with only `loop_ret` high. A cycle with both high counts as zero.
- R3: On the last cycle of each window the compensation value becomes itself plus that window's net count. A window with a net count of zero leaves it unchanged.
- R4: The compensation value saturates at +255 and -255.
- R5: The pulses produced from the value held during window k appear in cycles 512k+1 to 512k+512. There are exactly |value| of them: on `step_adv` if the value is positive, on `step_ret` if it is negative, and none if it is zero. The first pulse is in cycle 512k + ceil(512/|value|).
- R6: Within a window, consecutive pulses are floor(512/|value|) or ceil(512/|value|) cycles apart, and each pulse lasts one cycle.
- R7: `step_adv` and `step_ret` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| loop_adv | input | 1 | Advance step pulse from the loop filter |
| loop_ret | input | 1 | Retard step pulse from the loop filter |
| step_adv | output | 1 | Compensation pulse: advance the clock one step |
| step_ret | output | 1 | Compensation pulse: retard the clock one step |

## Verification
An input pulse sampled in window k first affects the outputs of window k+1. The compensation value changes on the edge that closes window k. The spreader acts on it from the next cycle, and its registered outputs add one more cycle, so window k+1's pulses are visible in cycles 512(k+1)+1 to 512(k+2). The bench keeps its own cycle count from reset release, samples on the falling edge, and assigns each observed pulse to its window with that offset. It checks a window's count, direction, first-pulse cycle and spacing only after the window's last cycle. Each scenario drives window k and is checked at 512(k+2)+1, so stimulus and observation never overlap.

// File: rtl/fcl_pkg.sv
// Package: shared types and helpers for the frequency compensation loop.
// Assumes nothing beyond plain two-state use of the enum values.
package fcl_pkg;

    // Direction of the compensation pulses for the current window.
    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_ADV  = 2'd1,
        STEP_RET  = 2'd2
    } step_dir_t;

    // Net contribution of one cycle: +1 advance only, -1 retard only, else 0.
    function automatic logic signed [1:0] step_delta(input logic adv, input logic ret);
        logic signed [1:0] d;
        unique case ({adv, ret})
            2'b10:   d = 2'sd1;
            2'b01:   d = -2'sd1;
            default: d = 2'sd0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/fcl_period_timer.sv
// Module: fcl_period_timer
// Free-running window timer. It raises win_last in the final cycle of every
// PERIOD-cycle window, with cycle 0 being the first cycle after reset release.
// Assumes PERIOD >= 2.
module fcl_period_timer #(
    parameter int PERIOD = 512
) (
    input  logic clk,
    input  logic rst_n,
    output logic win_last
);
    localparam int CNT_W = $clog2(PERIOD);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] pos_q;

    // Advance the position inside the window, wrapping at the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (pos_q == LAST_IDX) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_q + 1'b1;
        end
    end

    // Flag the final cycle of the window.
    always_comb begin
        win_last = (pos_q == LAST_IDX);
    end

endmodule

// File: rtl/fcl_net_counter.sv
// Module: fcl_net_counter
// Counts advance-minus-retard pulses within a window. net_total includes the
// current cycle, so the last cycle's pulse is credited to the closing window.
// The running count clears on the edge that ends the window.
// Assumes NET_W can hold +/-PERIOD.
module fcl_net_counter #(
    parameter int NET_W = 11
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    loop_adv,
    input  logic                    loop_ret,
    input  logic                    win_last,
    output logic signed [NET_W-1:0] net_total
);
    import fcl_pkg::*;

    logic signed [NET_W-1:0] net_q;
    logic signed [1:0]       delta;
    logic signed [NET_W-1:0] delta_ext;

    // Translate the two pulse inputs into a signed step.
    always_comb begin
        delta     = step_delta(loop_adv, loop_ret);
        delta_ext = {{(NET_W-2){delta[1]}}, delta};
        net_total = net_q + delta_ext;
    end

    // Accumulate within the window, restarting from zero at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            net_q <= '0;
        end else if (win_last) begin
            net_q <= '0;
        end else begin
            net_q <= net_total;
        end
    end

endmodule

// File: rtl/fcl_accumulator.sv
// Module: fcl_accumulator
// Holds the signed compensation value. On each window boundary it adds the
// window's net count and clamps the result to +/-LIMIT. Between boundaries
// it holds. Assumes LIMIT fits in ACC_W-1 magnitude bits.
module fcl_accumulator #(
    parameter int NET_W = 11,
    parameter int ACC_W = 9,
    parameter int LIMIT = 255
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    win_last,
    input  logic signed [NET_W-1:0] net_total,
    output logic signed [ACC_W-1:0] acc_val
);
    localparam int SUM_W = ((NET_W > ACC_W) ? NET_W : ACC_W) + 1;
    localparam logic signed [SUM_W-1:0] HI_BOUND = SUM_W'(LIMIT);
    localparam logic signed [SUM_W-1:0] LO_BOUND = -HI_BOUND;

    logic signed [SUM_W-1:0] sum_w;
    logic signed [ACC_W-1:0] acc_next;

    // Form the unclamped sum and apply saturation.
    always_comb begin
        sum_w = {{(SUM_W-ACC_W){acc_val[ACC_W-1]}}, acc_val}
              + {{(SUM_W-NET_W){net_total[NET_W-1]}}, net_total};
        if (sum_w > HI_BOUND) begin
            acc_next = ACC_W'(HI_BOUND);
        end else if (sum_w < LO_BOUND) begin
            acc_next = ACC_W'(LO_BOUND);
        end else begin
            acc_next = ACC_W'(sum_w);
        end
    end

    // Load the clamped sum only on the window boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_val <= '0;
        end else if (win_last) begin
            acc_val <= acc_next;
        end
    end

endmodule

// File: rtl/fcl_spreader.sv
// Module: fcl_spreader
// Emits |acc_val| single-cycle pulses per window with even spacing. It uses
// a phase register that gains |acc_val| each cycle and fires on reaching
// PERIOD. The register restarts at zero with each window. Direction follows
// the sign of acc_val. Outputs are registered, one cycle after the add.
// Assumes |acc_val| < PERIOD/2, so pulses never touch.
module fcl_spreader #(
    parameter int PERIOD = 512,
    parameter int ACC_W  = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    win_last,
    input  logic signed [ACC_W-1:0] acc_val,
    output logic                    step_adv,
    output logic                    step_ret
);
    import fcl_pkg::*;

    localparam int DDA_W = $clog2(2 * PERIOD);
    localparam int PH_W  = DDA_W - 1;
    localparam logic [DDA_W-1:0] PERIOD_V = DDA_W'(PERIOD);

    logic [PH_W-1:0]  phase_q;
    logic [ACC_W-1:0] mag;
    logic [DDA_W-1:0] phase_sum;
    logic [DDA_W-1:0] phase_next;
    logic             fire;
    step_dir_t        dir;

    // Magnitude and direction of the value being spread.
    always_comb begin
        mag = acc_val[ACC_W-1] ? ACC_W'(-acc_val) : ACC_W'(acc_val);
        if (acc_val > 0) begin
            dir = STEP_ADV;
        end else if (acc_val < 0) begin
            dir = STEP_RET;
        end else begin
            dir = STEP_NONE;
        end
    end

    // Phase step, overflow detection and wrapped remainder.
    always_comb begin
        phase_sum  = DDA_W'(phase_q) + DDA_W'(mag);
        fire       = (phase_sum >= PERIOD_V);
        phase_next = fire ? (phase_sum - PERIOD_V) : phase_sum;
    end

    // Update the phase register and restart it at each window boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (win_last) begin
            phase_q <= '0;
        end else begin
            phase_q <= PH_W'(phase_next);
        end
    end

    // Register the pulse onto the output selected by the direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_adv <= 1'b0;
            step_ret <= 1'b0;
        end else begin
            step_adv <= fire && (dir == STEP_ADV);
            step_ret <= fire && (dir == STEP_RET);
        end
    end

endmodule

// File: rtl/freq_comp_loop.sv
// Module: freq_comp_loop
// Top level of the feed-forward frequency compensation loop. It measures the
// net phase steps of each window, accumulates them into a saturating
// compensation value, and spreads that many pulses over the next window.
// Assumes LIMIT < PERIOD/2 and PERIOD >= 2.
module freq_comp_loop #(
    parameter int PERIOD = 512,
    parameter int LIMIT  = 255
) (
    input  logic clk,
    input  logic rst_n,
    input  logic loop_adv,
    input  logic loop_ret,
    output logic step_adv,
    output logic step_ret
);
    localparam int NET_W = $clog2(PERIOD + 1) + 1;
    localparam int ACC_W = $clog2(LIMIT + 1) + 1;

    logic                    win_last;
    logic signed [NET_W-1:0] net_total;
    logic signed [ACC_W-1:0] acc_val;

    // Window timing.
    fcl_period_timer #(.PERIOD(PERIOD)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_last (win_last)
    );

    // Per-window net step count.
    fcl_net_counter #(.NET_W(NET_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .loop_adv  (loop_adv),
        .loop_ret  (loop_ret),
        .win_last  (win_last),
        .net_total (net_total)
    );

    // Saturating compensation value.
    fcl_accumulator #(.NET_W(NET_W), .ACC_W(ACC_W), .LIMIT(LIMIT)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_last  (win_last),
        .net_total (net_total),
        .acc_val   (acc_val)
    );

    // Even pulse generation.
    fcl_spreader #(.PERIOD(PERIOD), .ACC_W(ACC_W)) u_spread (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_last (win_last),
        .acc_val  (acc_val),
        .step_adv (step_adv),
        .step_ret (step_ret)
    );

endmodule

// File: rtl/fcl_checker.sv
// Module: fcl_checker
// Property checks for freq_comp_loop, attached by bind. An independent cycle
// counter checks the window length.
module fcl_checker #(
    parameter int PERIOD = 512,
    parameter int LIMIT  = 255,
    parameter int ACC_W  = 9
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    win_last,
    input logic signed [ACC_W-1:0] acc_val,
    input logic                    step_adv,
    input logic                    step_ret
);
    localparam int GAP_W = $clog2(PERIOD);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(PERIOD - 1);
    localparam logic signed [ACC_W-1:0] LIM_V = ACC_W'(LIMIT);

    logic [GAP_W-1:0] gap_q;

    // Count cycles since the previous window boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (win_last) begin
            gap_q <= '0;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assert_window_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        win_last |-> (gap_q == GAP_LAST));

    assert_window_due_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_q == GAP_LAST) |-> win_last);

    assert_hold_between_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !win_last |=> $stable(acc_val));

    assert_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_val <= LIM_V) && (acc_val >= -LIM_V));

    assert_adv_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step_adv |-> ($past(acc_val) > 0));

    assert_ret_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step_ret |-> ($past(acc_val) < 0));

    assert_single_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_adv || step_ret) |=> !(step_adv || step_ret));

    assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_adv && step_ret));

endmodule

bind freq_comp_loop fcl_checker #(
    .PERIOD (PERIOD),
    .LIMIT  (LIMIT),
    .ACC_W  (ACC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .win_last (win_last),
    .acc_val  (acc_val),
    .step_adv (step_adv),
    .step_ret (step_ret)
);

// File: tb/sim_freq_comp_loop.sv
// Directed bench for freq_comp_loop. Each task drives one scenario and checks
// its own windows. Cycle c counts from the first cycle after reset release.
module sim_freq_comp_loop;

    localparam int WIN   = 512;
    localparam int LIM   = 255;
    localparam int NWIN  = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic loop_adv = 1'b0;
    logic loop_ret = 1'b0;
    logic step_adv;
    logic step_ret;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    int adv_n [NWIN];
    int ret_n [NWIN];
    int first_c [NWIN];
    int last_c [NWIN];
    int min_gap [NWIN];
    int max_gap [NWIN];
    int both_seen [NWIN];
    int net_in [NWIN];

    freq_comp_loop u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .loop_adv (loop_adv),
        .loop_ret (loop_ret),
        .step_adv (step_adv),
        .step_ret (step_ret)
    );

    // 125 MHz clock.
    always #4 clk = ~clk;

    // Cycle index since reset release.
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    // Record pulses per output window; window w spans cycles 512w+1..512w+512.
    always @(negedge clk) begin
        if (rst_n && cyc >= 1) begin
            automatic int w = (cyc - 1) / WIN;
            if (w < NWIN) begin
                if (step_adv && step_ret) both_seen[w]++;
                if (step_adv || step_ret) begin
                    if (step_adv) adv_n[w]++;
                    if (step_ret) ret_n[w]++;
                    if (first_c[w] < 0) first_c[w] = cyc;
                    if (last_c[w] >= 0) begin
                        automatic int g = cyc - last_c[w];
                        if (min_gap[w] < 0 || g < min_gap[w]) min_gap[w] = g;
                        if (g > max_gap[w]) max_gap[w] = g;
                    end
                    last_c[w] = cyc;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        if (v > LIM) return LIM;
        if (v < -LIM) return -LIM;
        return v;
    endfunction

    // Expected compensation value used for output window w (R3, R4).
    function automatic int value_for(input int w);
        int a = 0;
        for (int j = 0; j < w; j++) a = sat(a + net_in[j]);
        return a;
    endfunction

    task automatic wait_cycle(input int c);
        @(negedge clk);
        while (cyc < c) @(negedge clk);
    endtask

    // Drive one input window: 'both' cycles of both inputs, then advances, then retards.
    task automatic drive_window(input int k, input int n_both, input int n_adv, input int n_ret);
        wait_cycle(k * WIN);
        for (int i = 0; i < WIN; i++) begin
            loop_adv = (i < n_both) || (i >= n_both && i < n_both + n_adv);
            loop_ret = (i < n_both) || (i >= n_both + n_adv && i < n_both + n_adv + n_ret);
            @(negedge clk);
        end
        loop_adv = 1'b0;
        loop_ret = 1'b0;
        net_in[k] += n_adv - n_ret;
    endtask

    // Single advance pulse in cycle c.
    task automatic pulse_at(input int c);
        wait_cycle(c);
        loop_adv = 1'b1;
        @(negedge clk);
        loop_adv = 1'b0;
        net_in[c / WIN] += 1;
    endtask

    // Compare one finished output window against the model.
    task automatic check_window(input int w, input string req);
        int v = value_for(w);
        int m = (v < 0) ? -v : v;
        wait_cycle(WIN * (w + 1) + 1);
        check(adv_n[w] == ((v > 0) ? m : 0), req, $sformatf("adv count win %0d", w),
              adv_n[w], (v > 0) ? m : 0);
        check(ret_n[w] == ((v < 0) ? m : 0), req, $sformatf("ret count win %0d", w),
              ret_n[w], (v < 0) ? m : 0);
        check(both_seen[w] == 0, "R7", $sformatf("overlap win %0d", w), both_seen[w], 0);
        if (m > 0) begin
            check(first_c[w] == WIN * w + (WIN + m - 1) / m, "R5",
                  $sformatf("first pulse win %0d", w), first_c[w], WIN * w + (WIN + m - 1) / m);
        end
        if (m >= 2) begin
            check(min_gap[w] >= WIN / m, "R6", $sformatf("min gap win %0d", w),
                  min_gap[w], WIN / m);
            check(max_gap[w] <= (WIN + m - 1) / m, "R6", $sformatf("max gap win %0d", w),
                  max_gap[w], (WIN + m - 1) / m);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // R1: outputs quiet in reset and during the first window.
    task automatic t_reset();
        repeat (4) @(negedge clk);
        check(!step_adv, "R1", "step_adv in reset", step_adv, 0);
        check(!step_ret, "R1", "step_ret in reset", step_ret, 0);
        rst_n = 1'b1;
        check_window(0, "R1");
    endtask

    // R2, R5, R6: four advances give four pulses 128 cycles apart.
    task automatic t_basic();
        drive_window(1, 0, 4, 0);
        check_window(2, "R5");
        check(min_gap[2] == 128, "R6", "gap at four pulses", min_gap[2], 128);
    endtask

    // R3: accumulation across windows and holding when net is zero.
    task automatic t_accumulate();
        drive_window(4, 0, 0, 10);
        check_window(3, "R3");
        check_window(4, "R3");
        check_window(5, "R3");
    endtask

    // R2: simultaneous inputs cancel; balanced inputs leave the value unchanged.
    task automatic t_cancel();
        drive_window(7, 20, 3, 3);
        check_window(6, "R2");
        check_window(7, "R2");
        check_window(8, "R2");
    endtask

    // R2: a pulse in the last cycle counts for that window, the next one for the next.
    task automatic t_boundary();
        pulse_at(10 * WIN - 1);
        pulse_at(10 * WIN);
        check_window(10, "R2");
        check_window(11, "R2");
    endtask

    // R4: positive saturation, then further advances stay clamped.
    task automatic t_sat_pos();
        drive_window(13, 0, 300, 0);
        drive_window(14, 0, 100, 0);
        check_window(14, "R4");
        check_window(15, "R4");
    endtask

    // R4: negative saturation from the positive limit.
    task automatic t_sat_neg();
        drive_window(17, 0, 0, 512);
        check_window(18, "R4");
    endtask

    // R5: a value of zero gives no pulses.
    task automatic t_zero();
        drive_window(20, 0, 255, 0);
        check_window(21, "R5");
    endtask

    initial begin
        for (int i = 0; i < NWIN; i++) begin
            adv_n[i] = 0; ret_n[i] = 0; first_c[i] = -1; last_c[i] = -1;
            min_gap[i] = -1; max_gap[i] = 0; both_seen[i] = 0; net_in[i] = 0;
        end
        t_reset();
        t_basic();
        t_accumulate();
        t_cancel();
        t_boundary();
        t_sat_pos();
        t_sat_neg();
        t_zero();
        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (40000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            finish_run();
        end
    end

endmodule